// File: doc/BRIEF.md
# Flash Page Parity Code Engine

This block sits beside a memory-mapped flash data port and watches every byte that crosses it, whether software is reading the page out of the flash or writing it in. Over each run of 256 bytes it builds a Hamming-style code: six column-parity bits that describe which bit positions inside the bytes carry odd parity, and sixteen line-parity bits that describe which byte positions inside the block do. It does not touch the data path. It only samples the data-port strobe and the byte on it.

Software uses it in a fixed order. It writes the clear location, moves 256 bytes through the data port, and then reads the two line-parity bytes, the column-parity register and the byte counter. If the counter reads non-zero, the block was not transferred completely and the code is not trusted. The registers hold true (non-inverted) parity. Software inverts the values and packs them into the three stored code bytes. Comparison, correction, spare-area layout and bad-block handling all stay in software.

Top module: `nfc_ecc_engine`

## Requirements
- R1: After reset, both line-parity bytes, the column-parity register and the byte counter read 0.
- R2: Column parity (offset 0x08, bits 5..0, bits 7..6 read 0) accumulates by XOR over every accepted byte. Bit 0 covers data bits 0,2,4,6. Bit 1 covers 1,3,5,7. Bit 2 covers 0,1,4,5. Bit 3 covers 2,3,6,7. Bit 4 covers 0..3. Bit 5 covers 4..7.
- R3: For each accepted byte, take the XOR of its eight bits. For each counter bit k (0..7), that byte parity is XORed into line-parity bit 2k when counter bit k is 0, and into bit 2k+1 when it is 1. Line-parity bits 7..0 read at offset 0x00 and bits 15..8 at offset 0x04.
- R4: The byte counter (offset 0x0C) increments once per accepted byte, in either transfer direction, and reads 0 again after exactly 256 bytes.
- R5: A write to offset 0x10, with any data, zeroes the counter and all parity bits on the next clock. A byte accepted in the same cycle as that write is discarded.
- R6: Writes to any offset other than 0x10 change nothing, and reading any offset changes nothing.
- R7: Reads of offsets outside 0x00, 0x04, 0x08 and 0x0C return 0. Read data is combinational from the current state.
- R8: In a cycle with no accepted byte and no clear, the counter and all parity bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| port_valid | input | 1 | High for one cycle per byte accepted on the flash data port |
| port_byte | input | 8 | Byte on the data port, in either direction |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_rdata | output | 8 | Read data for reg_addr |

## Verification
The block is driven with four kinds of data. An incrementing byte pattern places distinct parities at every block position, so it shows whether each counter bit routes its parity to the correct line-parity half. A block of all 0xFF bytes has even parity in every byte and must leave line parity at zero, which exposes a wrong parity reduction. A block that is all zero except one single-bit byte at a known position must yield a unique syndrome, and this pins both the column mapping and the line mapping. A sparse pseudo-random stream with clears in the middle of a block, and with clears that coincide with a byte, separates correct clear priority and counter wrap from designs that merely count.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int unsigned ECC_DATA_W = 8;
  localparam int unsigned ECC_BLOCK  = 256;
  localparam int unsigned ECC_ADDR_W = 5;

  localparam logic [ECC_ADDR_W-1:0] OFS_LP_LO = 5'h00;
  localparam logic [ECC_ADDR_W-1:0] OFS_LP_HI = 5'h04;
  localparam logic [ECC_ADDR_W-1:0] OFS_COL   = 5'h08;
  localparam logic [ECC_ADDR_W-1:0] OFS_CNT   = 5'h0C;
  localparam logic [ECC_ADDR_W-1:0] OFS_CLR   = 5'h10;

  typedef enum logic [1:0] {ACC_HOLD, ACC_TAKE, ACC_CLEAR} acc_op_e;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ecc_colpar.sv
module ecc_colpar #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LOG_W = $clog2(DATA_W),
  localparam int unsigned CP_W  = 2 * LOG_W
) (
  input  logic [DATA_W-1:0] din,
  output logic [CP_W-1:0]   cp_tgl
);
  for (genvar l = 0; l < LOG_W; l++) begin : g_lvl
    logic even_half, odd_half;
    always_comb begin
      even_half = 1'b0;
      odd_half  = 1'b0;
      for (int j = 0; j < DATA_W; j++) begin
        if (((j >> l) & 1) == 0) even_half = even_half ^ din[j];
        else                     odd_half  = odd_half  ^ din[j];
      end
    end
    assign cp_tgl[2*l]   = even_half;
    assign cp_tgl[2*l+1] = odd_half;
  end
endmodule

// File: rtl/ecc_linepar.sv
module ecc_linepar #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned LP_W  = 2 * CNT_W
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  pos,
  output logic [LP_W-1:0]   lp_tgl
);
  logic bpar;
  assign bpar = ^din;

  for (genvar k = 0; k < CNT_W; k++) begin : g_bit
    assign lp_tgl[2*k]   = bpar & ~pos[k];
    assign lp_tgl[2*k+1] = bpar &  pos[k];
  end
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
  import ecc_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LP_W  = 16,
  parameter int unsigned CP_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_op_e          op,
  input  logic [LP_W-1:0]  lp_tgl,
  input  logic [CP_W-1:0]  cp_tgl,
  output logic [CNT_W-1:0] cnt_q,
  output logic [LP_W-1:0]  lp_q,
  output logic [CP_W-1:0]  cp_q
);
  logic [CNT_W-1:0] cnt_d;
  logic [LP_W-1:0]  lp_d;
  logic [CP_W-1:0]  cp_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    lp_d   = lp_q;
    cp_d   = cp_q;
    upd_en = 1'b0;
    unique case (op)
      ACC_CLEAR: begin
        cnt_d  = '0;
        lp_d   = '0;
        cp_d   = '0;
        upd_en = 1'b1;
      end
      ACC_TAKE: begin
        cnt_d  = cnt_q + 1'b1;
        lp_d   = lp_q ^ lp_tgl;
        cp_d   = cp_q ^ cp_tgl;
        upd_en = 1'b1;
      end
      default: upd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lp_q  <= '0;
      cp_q  <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      lp_q  <= lp_d;
      cp_q  <= cp_d;
    end
  end
endmodule

// File: rtl/ecc_rdmux.sv
module ecc_rdmux
  import ecc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LP_W   = 16,
  parameter int unsigned CP_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [LP_W-1:0]   lp_q,
  input  logic [CP_W-1:0]   cp_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned LP_HALF = LP_W / 2;

  logic [LP_HALF-1:0] lp_lo, lp_hi;
  assign lp_lo = lp_q[LP_HALF-1:0];
  assign lp_hi = lp_q[LP_W-1:LP_HALF];

  always_comb begin
    unique case (addr)
      OFS_LP_LO: rdata = DATA_W'(lp_lo);
      OFS_LP_HI: rdata = DATA_W'(lp_hi);
      OFS_COL:   rdata = DATA_W'(cp_q);
      OFS_CNT:   rdata = DATA_W'(cnt_q);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/nfc_ecc_engine.sv
module nfc_ecc_engine
  import ecc_pkg::*;
#(
  parameter int unsigned DATA_W      = ECC_DATA_W,
  parameter int unsigned BLOCK_BYTES = ECC_BLOCK,
  parameter int unsigned ADDR_W      = ECC_ADDR_W,
  localparam int unsigned CNT_W = $clog2(BLOCK_BYTES),
  localparam int unsigned LP_W  = 2 * CNT_W,
  localparam int unsigned CP_W  = 2 * $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_valid,
  input  logic [DATA_W-1:0] port_byte,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic             rst_n_int;
  logic             clr_hit;
  acc_op_e          op;
  logic [LP_W-1:0]  lp_tgl;
  logic [CP_W-1:0]  cp_tgl;
  logic [CNT_W-1:0] cnt_q;
  logic [LP_W-1:0]  lp_q;
  logic [CP_W-1:0]  cp_q;

  ecc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  assign clr_hit = reg_wr && (reg_addr == OFS_CLR);

  always_comb begin
    if (clr_hit)         op = ACC_CLEAR;
    else if (port_valid) op = ACC_TAKE;
    else                 op = ACC_HOLD;
  end

  ecc_colpar #(.DATA_W(DATA_W)) u_col (.din(port_byte), .cp_tgl(cp_tgl));

  ecc_linepar #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_line (
    .din(port_byte), .pos(cnt_q), .lp_tgl(lp_tgl)
  );

  ecc_accum #(.CNT_W(CNT_W), .LP_W(LP_W), .CP_W(CP_W)) u_acc (
    .clk(clk), .rst_n(rst_n_int), .op(op), .lp_tgl(lp_tgl), .cp_tgl(cp_tgl),
    .cnt_q(cnt_q), .lp_q(lp_q), .cp_q(cp_q)
  );

  ecc_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LP_W(LP_W), .CP_W(CP_W)) u_rd (
    .addr(reg_addr), .cnt_q(cnt_q), .lp_q(lp_q), .cp_q(cp_q), .rdata(reg_rdata)
  );
endmodule

// File: rtl/ecc_engine_chk.sv
module ecc_engine_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LP_W   = 16,
  parameter int unsigned CP_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_valid,
  input logic [DATA_W-1:0] port_byte,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [LP_W-1:0]   lp_q,
  input logic [CP_W-1:0]   cp_q
);
  logic clr, take, mapped;
  assign clr    = reg_wr && (reg_addr == 5'h10);
  assign take   = port_valid && !clr;
  assign mapped = (reg_addr == 5'h00) || (reg_addr == 5'h04) ||
                  (reg_addr == 5'h08) || (reg_addr == 5'h0C);

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && (lp_q == '0) && (cp_q == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_valid && !clr) |=> $stable(cnt_q) && $stable(lp_q) && $stable(cp_q));

  assert_col_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((cp_q[5] ^ cp_q[4] ^ $past(cp_q[5]) ^ $past(cp_q[4])) == $past(^port_byte)));

  assert_line_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($countones(lp_q ^ $past(lp_q)) == ($past(^port_byte) ? CNT_W : 0)));

  assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == '0);
endmodule

bind nfc_ecc_engine ecc_engine_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LP_W(LP_W), .CP_W(CP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_int), .port_valid(port_valid), .port_byte(port_byte),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .cnt_q(cnt_q), .lp_q(lp_q), .cp_q(cp_q)
);

// File: tb/sim_nfc_ecc_engine.sv
`timescale 1ns/100ps
module sim_nfc_ecc_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_valid = 1'b0;
  logic [7:0] port_byte = 8'h00;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = 5'h00;
  logic [7:0] reg_rdata;

  int vectors = 0;
  int errors  = 0;

  // behavioural reference state
  int mcnt = 0;
  int mlp[16];
  int mcp[6];

  always #2 clk = ~clk;

  nfc_ecc_engine u0 (
    .clk(clk), .rst_n(rst_n), .port_valid(port_valid), .port_byte(port_byte),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  function automatic int expected(input int a);
    int v = 0;
    case (a)
      'h00: for (int i = 0; i < 8; i++) v += mlp[i] << i;
      'h04: for (int i = 0; i < 8; i++) v += mlp[8+i] << i;
      'h08: for (int i = 0; i < 6; i++) v += mcp[i] << i;
      'h0C: v = mcnt;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      'h00, 'h04: return "R3";
      'h08:       return "R2";
      'h0C:       return "R4";
      default:    return "R7";
    endcase
  endfunction

  function automatic bit in_group(input int bitpos, input int g);
    case (g)
      0: return (bitpos % 2) == 0;
      1: return (bitpos % 2) == 1;
      2: return (bitpos % 4) < 2;
      3: return (bitpos % 4) >= 2;
      4: return bitpos < 4;
      default: return bitpos >= 4;
    endcase
  endfunction

  task automatic model_reset();
    mcnt = 0;
    foreach (mlp[i]) mlp[i] = 0;
    foreach (mcp[i]) mcp[i] = 0;
  endtask

  task automatic model_apply(input bit v, input int b, input bit w, input int a);
    int ones;
    if (w && a == 'h10) begin
      model_reset();
    end else if (v) begin
      ones = 0;
      for (int j = 0; j < 8; j++) ones += (b >> j) & 1;
      for (int k = 0; k < 8; k++) begin
        if (((mcnt >> k) & 1) == 0) mlp[2*k]   ^= ones % 2;
        else                        mlp[2*k+1] ^= ones % 2;
      end
      for (int g = 0; g < 6; g++)
        for (int j = 0; j < 8; j++)
          if (in_group(j, g)) mcp[g] ^= (b >> j) & 1;
      mcnt = (mcnt + 1) % 256;
    end
  endtask

  task automatic check(input string tag, input int a);
    int e;
    e = expected(a);
    vectors++;
    if (int'(reg_rdata) != e) begin
      errors++;
      $display("FAIL %s addr=%02h got=%02h exp=%02h t=%0t", tag, a, reg_rdata, e, $time);
    end
  endtask

  // one clock: drive at negedge, compare current state, then advance the model
  task automatic step(input bit v, input int b, input bit w, input int a, input string tag);
    @(negedge clk);
    port_valid = v;
    port_byte  = 8'(b);
    reg_wr     = w;
    reg_addr   = 5'(a);
    #1;
    check((tag == "") ? tag_of(a) : tag, a);
    @(posedge clk);
    model_apply(v, b, w, a);
  endtask

  task automatic read_all(input string tag);
    step(0, 0, 0, 'h00, tag);
    step(0, 0, 0, 'h04, tag);
    step(0, 0, 0, 'h08, tag);
    step(0, 0, 0, 'h0C, tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int lfsr;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset values
    read_all("R1");
    step(0, 0, 0, 'h14, "R7");
    step(0, 0, 0, 'h1C, "R7");

    // incrementing block, reads rotate every cycle; counter wraps (R4)
    for (int i = 0; i < 256; i++) step(1, i, 0, (i % 4) * 4, "");
    step(0, 0, 0, 'h0C, "R4");
    read_all("R3");

    // R6: writes to non-clear offsets ignored; repeated reads harmless
    step(0, 0, 1, 'h00, "R6");
    step(0, 0, 1, 'h08, "R6");
    step(0, 0, 1, 'h0C, "R6");
    read_all("R6");
    read_all("R6");

    // R5: clear then all-0xFF block
    step(0, 0, 1, 'h10, "R5");
    read_all("R5");
    for (int i = 0; i < 256; i++) step(1, 'hFF, 0, (i % 4) * 4, "");
    read_all("R3");

    // single-bit byte at position 0x5A in a zero block
    step(0, 0, 1, 'h10, "R5");
    for (int i = 0; i < 256; i++) step(1, (i == 'h5A) ? 'h20 : 'h00, 0, (i % 4) * 4, "");
    read_all("R2");

    // sparse pseudo-random traffic with idle gaps (R8) and clears
    lfsr = 'hACE1;
    for (int i = 0; i < 900; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 'hB400 : 0)) & 'hFFFF;
      if (i % 97 == 50)      step(1, lfsr & 'hFF, 1, 'h10, "R5");
      else if (i % 7 == 3)   step(0, lfsr & 'hFF, 0, (i % 8) * 4, "R8");
      else                   step(1, lfsr & 'hFF, 0, (i % 8) * 4, "");
    end
    read_all("R8");

    // R5: clear with simultaneous byte discards it
    step(1, 'h01, 1, 'h10, "R5");
    read_all("R5");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule